// File: doc/BRIEF.md
# Programmable 13-Bit Interval Timer

This block is a general-purpose down-counting interval timer. A single 16-bit configuration word holds everything it needs: a 13-bit interval length, a tick-source select and two enables. It advances either on an internal tick that fires every second system clock, or on a tick supplied by a neighbouring counter. The second option lets two such counters be chained into a 26-bit interval. At the end of each interval it emits a one-cycle interrupt request and starts the next interval by itself.

Software writes the word through a write strobe and data bus. The master enable can only be cleared. Once it is cleared the timer stays silent until reset. An interval length of zero never requests an interrupt. Rewriting the length to zero while the timer runs therefore lets the interval in progress finish with one final request and then stops further requests. This gives single-pass operation.

Top module: `interval_timer13`

## Requirements
- R1: The configuration word decodes as follows. Bits 12..0 are the interval length N. Bit 13 selects the tick source (0 = internal half-rate tick, 1 = external cascade tick). Bit 14 is the run bit. Bit 15 is the master enable.
- R2: After reset the master enable is 1, the run bit is 0, the source is the internal tick and the length is 0. `irq` stays low and no counting happens until a write sets the run bit.
- R3: With the internal source and length N >= 1, `irq` pulses every 2N system clocks. For example, writing 0xC008 gives a request every 16 clocks.
- R4: With the cascade source, each clock in which `casc_tick` is high counts as one tick, and `irq` is raised after exactly N such ticks.
- R5: `irq` is high for one clock per interval end and is low in the clock that follows it when the internal source is used.
- R6: A length of zero never raises `irq`, with either source.
- R7: Rewriting the length to zero while running lets the interval in progress end with one final `irq`, after which no further request occurs.
- R8: Once a write clears the master enable, no later write can set it again before reset, and `irq` stays low.
- R9: While the run bit is 0 the counter does not advance and no request is raised. A write that sets the run bit from the stopped state begins a fresh full interval.
- R10: A write made while the timer runs changes only the length used at the next reload. The interval already in progress ends on its original schedule.
- R11: A start write (run and enable set while the timer is stopped) loads the length, so the first request arrives one full interval (2N clocks on the internal source) after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word written when `cfg_we` is high |
| casc_tick | input | 1 | Tick from a neighbouring counter, one per high clock |
| irq | output | 1 | Registered one-cycle interrupt request |

## Verification
The embedded assertions check several rules on every clock:
- the master enable never returns to 1 after it is cleared;
- the internal tick never fires in two adjacent clocks;
- the counter holds its value in any clock with no tick and no start;
- the counter steps down by exactly one per tick above one;
- a tick that finds the counter at zero never produces a request.

Other behaviours show only through the bench's scenarios:
- the exact interval lengths across a sweep of N for both sources;
- the single final request after a length is rewritten to zero;
- the deferred effect of a length change made mid-interval;
- the fresh interval after a pause.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  typedef enum logic {
    SRC_HALF = 1'b0,
    SRC_CASC = 1'b1
  } tick_src_e;

endpackage

// File: rtl/itimer_cfg.sv
module itimer_cfg
  import itimer_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CNT_W+2:0]   wdata,
  output logic               active,
  output tick_src_e          src,
  output logic [CNT_W-1:0]   reload,
  output logic               start
);

  localparam int SRC_BIT = CNT_W;
  localparam int RUN_BIT = CNT_W + 1;
  localparam int EN_BIT  = CNT_W + 2;

  logic enable_q;
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b1;
      run_q    <= 1'b0;
      src      <= SRC_HALF;
      reload   <= '0;
    end else if (we) begin
      enable_q <= enable_q & wdata[EN_BIT];
      run_q    <= wdata[RUN_BIT];
      src      <= tick_src_e'(wdata[SRC_BIT]);
      reload   <= wdata[CNT_W-1:0];
    end
  end

  assign active = enable_q & run_q;
  // a start is a write that turns counting on from the stopped state
  assign start  = we & wdata[RUN_BIT] & wdata[EN_BIT] & enable_q & ~active;

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !enable_q |=> !enable_q); // R8

  AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable_q |-> !start); // R8

endmodule

// File: rtl/itimer_tick.sv
module itimer_tick
  import itimer_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      active,
  input  tick_src_e src,
  input  logic      casc_tick,
  input  logic      restart,
  output logic      tick
);

  logic tick_half;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick_half = active & (src == SRC_HALF);
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          phase <= '0;
        end else if (active && src == SRC_HALF) begin
          phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
      end

      assign tick_half = active & (src == SRC_HALF) & (phase == LAST);

      AST_HALF_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick_half |=> !tick_half); // R3
    end
  endgenerate

  assign tick = (src == SRC_CASC) ? (active & casc_tick) : tick_half;

endmodule

// File: rtl/itimer_count.sv
module itimer_count #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] reload,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        count <= start_val;
      end else if (tick) begin
        if (count <= ONE) begin
          count <= reload;
          irq   <= (count == ONE);
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(count)); // R9

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && !start && count > ONE) |=> (count == $past(count) - ONE)); // R3

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !start && count == '0) |=> !irq); // R6

  AST_IRQ_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick)); // R5

endmodule

// File: rtl/interval_timer13.sv
module interval_timer13
  import itimer_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter int DIV   = 2,
  localparam int CFG_W = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             casc_tick,
  output logic             irq
);

  logic             active;
  tick_src_e        src;
  logic [CNT_W-1:0] reload;
  logic             start;
  logic             tick;

  itimer_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .active (active),
    .src    (src),
    .reload (reload),
    .start  (start)
  );

  itimer_tick #(.DIV(DIV)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .src       (src),
    .casc_tick (casc_tick),
    .restart   (start),
    .tick      (tick)
  );

  itimer_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start     (start),
    .start_val (cfg_wdata[CNT_W-1:0]),
    .reload    (reload),
    .irq       (irq)
  );

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |=> !irq); // R9

endmodule

// File: tb/interval_timer13_test.sv
module interval_timer13_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        casc_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  interval_timer13 uut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .casc_tick (casc_tick),
    .irq       (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    casc_tick = 1'b0;
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // clocks (and cascade pulses) until irq seen; n = -1 on timeout
  task automatic wait_irq(input int limit, input bit casc, output int n, output int pulses);
    bit got;
    got = 1'b0;
    n = 0;
    pulses = 0;
    while (!got && n < limit) begin
      @(negedge clk);
      n++;
      if (irq) got = 1'b1;
      else if (casc) begin
        casc_tick = (n % 3 == 0);
        if (casc_tick) pulses++;
      end
    end
    casc_tick = 1'b0;
    if (!got) n = -1;
  endtask

  task automatic count_irq(input int cycles, input bit casc, output int c);
    c = 0;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      if (irq) c++;
      if (casc) casc_tick = (k % 2 == 0);
    end
    casc_tick = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, p, c;
    do_reset();

    // R2: reset state, no counting and irq low, even with cascade ticks
    check(irq == 1'b0, "R2 irq after reset", int'(irq), 0);
    count_irq(40, 1'b1, c);
    check(c == 0, "R2 idle after reset", c, 0);

    // R3 / R11 / R5: sweep lengths on the internal half-rate tick
    for (int len = 1; len <= 12; len++) begin
      wr(16'h8000);
      wr(16'hC000 | 16'(len));
      wait_irq(200, 1'b0, n, p);
      check(n == 2 * len, "R11 first interval", n, 2 * len);
      wait_irq(200, 1'b0, n, p);
      check(n == 2 * len, "R3 periodic interval", n, 2 * len);
      @(negedge clk);
      check(irq == 1'b0, "R5 single-cycle pulse", int'(irq), 0);
    end

    // R3: the 0xC008 example gives 16 clocks
    wr(16'h8000);
    wr(16'hC008);
    wait_irq(100, 1'b0, n, p);
    check(n == 16, "R3 0xC008 period", n, 16);

    // R1: full 13-bit length field
    wr(16'h8000);
    wr(16'hDFFF);
    wait_irq(20000, 1'b0, n, p);
    check(n == 16382, "R1 max length", n, 16382);

    // R4 / R1: cascade source, bit 13
    for (int len = 1; len <= 10; len++) begin
      wr(16'h8000);
      wr(16'hE000 | 16'(len));
      wait_irq(200, 1'b1, n, p);
      check(p == len && n > 0, "R4 cascade first", p, len);
      wait_irq(200, 1'b1, n, p);
      check(p == len && n > 0, "R4 cascade periodic", p, len);
    end

    // R6: zero length is silent with both sources
    wr(16'h8000);
    wr(16'hC000);
    count_irq(100, 1'b0, c);
    check(c == 0, "R6 zero half-rate", c, 0);
    wr(16'h8000);
    wr(16'hE000);
    count_irq(100, 1'b1, c);
    check(c == 0, "R6 zero cascade", c, 0);

    // R10: mid-run length change applies at next reload
    wr(16'h8000);
    wr(16'hC004);
    wait_irq(100, 1'b0, n, p);
    check(n == 8, "R10 before change", n, 8);
    wr(16'hC00A);
    wait_irq(100, 1'b0, n, p);
    check(n == 6, "R10 interval in progress", n, 6);
    wait_irq(100, 1'b0, n, p);
    check(n == 20, "R10 new length", n, 20);

    // R7: single pass by rewriting zero
    wr(16'h8000);
    wr(16'hC005);
    wait_irq(100, 1'b0, n, p);
    check(n == 10, "R7 first interval", n, 10);
    wr(16'hC000);
    count_irq(100, 1'b0, c);
    check(c == 1, "R7 one final request", c, 1);

    // R9: pause stops counting, restart gives a full interval
    wr(16'h8000);
    wr(16'hC006);
    repeat (3) @(negedge clk);
    wr(16'h8006);
    count_irq(60, 1'b0, c);
    check(c == 0, "R9 paused silent", c, 0);
    wr(16'hC006);
    wait_irq(100, 1'b0, n, p);
    check(n == 12, "R9 fresh interval after restart", n, 12);

    // R8: cleared enable is sticky
    wr(16'h4005);
    count_irq(60, 1'b0, c);
    check(c == 0, "R8 disabled silent", c, 0);
    wr(16'hC005);
    count_irq(60, 1'b0, c);
    check(c == 0, "R8 enable cannot return", c, 0);
    wr(16'hE001);
    count_irq(60, 1'b1, c);
    check(c == 0, "R8 cascade while disabled", c, 0);

    // R2: reset restores enable
    do_reset();
    wr(16'hC003);
    wait_irq(100, 1'b0, n, p);
    check(n == 6, "R2 enable restored by reset", n, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule